// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write path of a NOR-style flash bus. It watches word-wide write cycles and follows the command sequences addressed to each bank. A bank can enter a persistent fast-program mode after a three-cycle unlock. In that mode one program costs two writes instead of four. The bank stays in the mode until a two-cycle exit or a three-cycle reset sequence. Every completed program sequence produces a one-clock request that carries the target address and data. A write that breaks a sequence, or that bypass mode does not accept, raises a one-clock error flag.

The array, the embedded program and erase timers, sector protection and the acceleration supply are all outside this block. An external `busy` input stands in for an embedded operation in progress. While `busy` is high the block ignores writes.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A synchronous active-high `rst` puts every bank in mode code 0 (read) with no pending sequence, and holds `prog_req` and `cmd_err` low.
- R2: Each bank reports a 2-bit mode in `bank_mode[2*b+1:2*b]`: 0 read, 1 bypass, 2 partial sequence begun in read mode, 3 partial sequence begun in bypass mode. Three writes move a bank from read to bypass: low address 555h with data 00AAh, then 2AAh with 0055h, then 555h with 0020h. Only the low CMP_W (12) address bits are compared.
- R3: In bypass, a write of 00A0h at any address, followed by any write to the same bank, raises `prog_req` for exactly one clock. The request comes in the cycle after the second write's clock edge, with `prog_addr`/`prog_data` equal to that write. The bank then returns to bypass. `prog_req` and `cmd_err` are never high together.
- R4: In read mode, the four-write sequence 555h/00AAh, 2AAh/0055h, 555h/00A0h, then a data write raises `prog_req` with the data write's address and data. The bank returns to read.
- R5: In bypass idle, a write whose data is not 00A0h, not 0090h, and not 00AAh at low address 555h is rejected. The bank pulses `cmd_err` and stays in bypass. A lone 00F0h write is rejected too.
- R6: In bypass, 0090h at any address in the bank, followed by 0000h at any address in the bank, returns the bank to read. Bypass never drops to read in a single cycle.
- R7: In bypass, the writes 555h/00AAh, 2AAh/0055h, then 00F0h at any address return the bank to read.
- R8: A write that breaks a partial sequence pulses `cmd_err` for one clock. The bank goes back to read if the sequence began in read mode, and back to bypass if it began in bypass.
- R9: A write is accepted only when `wr_en` is high and `busy` is low. Any other cycle leaves every bank's mode unchanged and produces no request and no error.
- R10: The top BANK_W address bits pick the bank. A write changes only the state of the bank it selects.
- R11: In read mode with no partial sequence, a write other than 00AAh at low address 555h is ignored without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write cycle strobe |
| wr_addr | input | ADDR_W | Word address; top BANK_W bits pick the bank |
| wr_data | input | DATA_W | Write data / command word |
| busy | input | 1 | Embedded operation in progress; writes ignored |
| bank_mode | output | 2*2^BANK_W | Per-bank mode codes |
| prog_req | output | 1 | One-clock program request |
| prog_addr | output | ADDR_W | Address of the last program request |
| prog_data | output | DATA_W | Data of the last program request |
| cmd_err | output | 1 | One-clock illegal-command flag |

## Verification
A bank's sequence state is visible at `bank_mode` right after the edge that accepts a write. A tracker that is wrong by one step therefore shows a wrong mode code in the next cycle. It shows the wrong code again when the following write produces a missing or spurious `prog_req` or `cmd_err`. A mistake in bank selection shows up as a mode change in a bank that received no write. A mistake in the exit or reset paths shows up as a bank that stays in bypass, or leaves it, one write too early or too late.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   typedef enum logic [3:0] {
      S_READ, S_UL1, S_UL2, S_NPROG,
      S_BYP, S_BPROG, S_BEXIT, S_BRST1, S_BRST2
   } seq_state_e;

   localparam logic [1:0] MODE_READ = 2'd0;
   localparam logic [1:0] MODE_BYP  = 2'd1;
   localparam logic [1:0] MODE_NSEQ = 2'd2;
   localparam logic [1:0] MODE_BSEQ = 2'd3;

   localparam logic [7:0] CMD_KEY1  = 8'hAA;
   localparam logic [7:0] CMD_KEY2  = 8'h55;
   localparam logic [7:0] CMD_ENTER = 8'h20;
   localparam logic [7:0] CMD_PROG  = 8'hA0;
   localparam logic [7:0] CMD_EXIT1 = 8'h90;
   localparam logic [7:0] CMD_EXIT2 = 8'h00;
   localparam logic [7:0] CMD_RST   = 8'hF0;

   function automatic logic [1:0] mode_of(input seq_state_e s);
      case (s)
         S_READ:                  return MODE_READ;
         S_BYP:                   return MODE_BYP;
         S_UL1, S_UL2, S_NPROG:   return MODE_NSEQ;
         default:                 return MODE_BSEQ;
      endcase
   endfunction

endpackage

// File: rtl/flash_bank_dec.sv
module flash_bank_dec #(
   parameter int BANK_W = 2,
   localparam int NB    = 1 << BANK_W
) (
   input  logic              en,
   input  logic [BANK_W-1:0] sel,
   output logic [NB-1:0]     hit
);
   for (genvar b = 0; b < NB; b++) begin : g_hit
      assign hit[b] = en && (sel == BANK_W'(b));
   end
endmodule

// File: rtl/flash_bank_seq.sv
module flash_bank_seq
   import flash_cmd_pkg::*;
#(
   parameter int            CMP_W       = 12,
   parameter int            DATA_W      = 16,
   parameter logic [11:0]   KEY_ADDR_A  = 12'h555,
   parameter logic [11:0]   KEY_ADDR_B  = 12'h2AA,
   parameter bit            STD_PROG_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              hit,
   input  logic [CMP_W-1:0]  addr_lo,
   input  logic [DATA_W-1:0] data,
   output logic [1:0]        mode,
   output logic              fire,
   output logic              bad
);
   seq_state_e st, nxt;
   logic       at_a, at_b;

   assign at_a = (addr_lo == CMP_W'(KEY_ADDR_A));
   assign at_b = (addr_lo == CMP_W'(KEY_ADDR_B));

   function automatic logic is_cmd(input logic [DATA_W-1:0] d, input logic [7:0] c);
      return d == DATA_W'(c);
   endfunction

   always_comb begin
      nxt  = st;
      fire = 1'b0;
      bad  = 1'b0;
      if (hit) begin
         case (st)
            S_READ:
               if (at_a && is_cmd(data, CMD_KEY1)) nxt = S_UL1;
            S_UL1:
               if (at_b && is_cmd(data, CMD_KEY2)) nxt = S_UL2;
               else begin nxt = S_READ; bad = 1'b1; end
            S_UL2:
               if (at_a && is_cmd(data, CMD_ENTER)) nxt = S_BYP;
               else if (STD_PROG_EN && at_a && is_cmd(data, CMD_PROG)) nxt = S_NPROG;
               else begin nxt = S_READ; bad = 1'b1; end
            S_NPROG: begin
               fire = 1'b1;
               nxt  = S_READ;
            end
            S_BYP:
               if (is_cmd(data, CMD_PROG))                nxt = S_BPROG;
               else if (is_cmd(data, CMD_EXIT1))          nxt = S_BEXIT;
               else if (at_a && is_cmd(data, CMD_KEY1))   nxt = S_BRST1;
               else bad = 1'b1;
            S_BPROG: begin
               fire = 1'b1;
               nxt  = S_BYP;
            end
            S_BEXIT:
               if (is_cmd(data, CMD_EXIT2)) nxt = S_READ;
               else begin nxt = S_BYP; bad = 1'b1; end
            S_BRST1:
               if (at_b && is_cmd(data, CMD_KEY2)) nxt = S_BRST2;
               else begin nxt = S_BYP; bad = 1'b1; end
            S_BRST2:
               if (is_cmd(data, CMD_RST)) nxt = S_READ;
               else begin nxt = S_BYP; bad = 1'b1; end
            default: nxt = S_READ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) st <= S_READ;
      else     st <= nxt;
   end

   assign mode = mode_of(st);
endmodule

// File: rtl/flash_evt_reg.sv
module flash_evt_reg #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int NB     = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NB-1:0]     fire_vec,
   input  logic [NB-1:0]     bad_vec,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic              prog_req,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [DATA_W-1:0] prog_data,
   output logic              cmd_err
);
   logic any_fire;
   assign any_fire = |fire_vec;

   always_ff @(posedge clk) begin
      if (rst) begin
         prog_req  <= 1'b0;
         cmd_err   <= 1'b0;
         prog_addr <= '0;
         prog_data <= '0;
      end else begin
         prog_req <= any_fire;
         cmd_err  <= |bad_vec;
         if (any_fire) begin
            prog_addr <= addr;
            prog_data <= data;
         end
      end
   end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 16,
   parameter int BANK_W      = 2,
   parameter int CMP_W       = 12,
   parameter bit STD_PROG_EN = 1'b1,
   localparam int NUM_BANKS  = 1 << BANK_W
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [DATA_W-1:0]      wr_data,
   input  logic                   busy,
   output logic [2*NUM_BANKS-1:0] bank_mode,
   output logic                   prog_req,
   output logic [ADDR_W-1:0]      prog_addr,
   output logic [DATA_W-1:0]      prog_data,
   output logic                   cmd_err
);
   if (BANK_W < 1 || BANK_W >= ADDR_W) begin : g_chk_bank
      $error("flash_cmd_decoder: BANK_W must lie in 1..ADDR_W-1");
   end
   if (CMP_W < 10 || CMP_W > 12 || CMP_W > ADDR_W - BANK_W) begin : g_chk_cmp
      $error("flash_cmd_decoder: CMP_W must lie in 10..12 and fit below the bank bits");
   end
   if (DATA_W < 8) begin : g_chk_data
      $error("flash_cmd_decoder: DATA_W must be at least 8");
   end

   logic                 accept;
   logic [NUM_BANKS-1:0] hit, fire_vec, bad_vec;

   assign accept = wr_en && !busy;

   flash_bank_dec #(.BANK_W(BANK_W)) u_dec (
      .en  (accept),
      .sel (wr_addr[ADDR_W-1 -: BANK_W]),
      .hit (hit)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      flash_bank_seq #(
         .CMP_W       (CMP_W),
         .DATA_W      (DATA_W),
         .STD_PROG_EN (STD_PROG_EN)
      ) u_seq (
         .clk     (clk),
         .rst     (rst),
         .hit     (hit[b]),
         .addr_lo (wr_addr[CMP_W-1:0]),
         .data    (wr_data),
         .mode    (bank_mode[2*b +: 2]),
         .fire    (fire_vec[b]),
         .bad     (bad_vec[b])
      );
   end

   flash_evt_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NB(NUM_BANKS)) u_evt (
      .clk       (clk),
      .rst       (rst),
      .fire_vec  (fire_vec),
      .bad_vec   (bad_vec),
      .addr      (wr_addr),
      .data      (wr_data),
      .prog_req  (prog_req),
      .prog_addr (prog_addr),
      .prog_data (prog_data),
      .cmd_err   (cmd_err)
   );
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
   parameter int NB = 4
) (
   input logic          clk,
   input logic          rst,
   input logic          wr_en,
   input logic          busy,
   input logic [2*NB-1:0] bank_mode,
   input logic          prog_req,
   input logic          cmd_err
);
   AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (bank_mode == '0) && !prog_req && !cmd_err); // R1

   AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
      !(prog_req && cmd_err)); // R3

   AST_REQ_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
      prog_req |-> $past(wr_en && !busy)); // R3

   AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
      cmd_err |-> $past(wr_en && !busy)); // R8

   AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && ($past(busy) || !$past(wr_en))) |-> $stable(bank_mode) && !prog_req && !cmd_err); // R9

   for (genvar b = 0; b < NB; b++) begin : g_bank
      AST_BYP_NO_JUMP: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && $past(bank_mode[2*b +: 2]) == 2'd1) |-> bank_mode[2*b +: 2] != 2'd0); // R6
   end
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.NB(NUM_BANKS)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .wr_en     (wr_en),
   .busy      (busy),
   .bank_mode (bank_mode),
   .prog_req  (prog_req),
   .cmd_err   (cmd_err)
);

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        busy = 1'b0;
   logic [7:0]  bank_mode;
   logic        prog_req, cmd_err;
   logic [15:0] prog_addr, prog_data;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   flash_cmd_decoder dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .busy(busy), .bank_mode(bank_mode), .prog_req(prog_req),
      .prog_addr(prog_addr), .prog_data(prog_data), .cmd_err(cmd_err)
   );

   typedef struct packed {
      logic        en;
      logic        bsy;
      logic [15:0] a;
      logic [15:0] d;
      logic        xp;
      logic        xi;
      logic [1:0]  m0;
      logic [1:0]  m1;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 33;
   localparam vec_t VEC [NV] = '{
      '{1'b1,1'b0,16'h0555,16'h00AA,1'b0,1'b0,2'd2,2'd0,4'd2},  // R2 key 1
      '{1'b1,1'b0,16'h02AA,16'h0055,1'b0,1'b0,2'd2,2'd0,4'd2},  // R2 key 2
      '{1'b1,1'b0,16'h0555,16'h0020,1'b0,1'b0,2'd1,2'd0,4'd2},  // R2 enter bypass
      '{1'b1,1'b0,16'h0123,16'h00A0,1'b0,1'b0,2'd3,2'd0,4'd3},  // R3 program setup
      '{1'b1,1'b0,16'h0777,16'h1234,1'b1,1'b0,2'd1,2'd0,4'd3},  // R3 program data
      '{1'b1,1'b0,16'h0010,16'h0080,1'b0,1'b1,2'd1,2'd0,4'd5},  // R5 rejected command
      '{1'b1,1'b0,16'h0555,16'h00F0,1'b0,1'b1,2'd1,2'd0,4'd5},  // R5 lone reset rejected
      '{1'b1,1'b0,16'h4555,16'h00AA,1'b0,1'b0,2'd1,2'd2,4'd10}, // R10 bank 1 key 1
      '{1'b1,1'b0,16'h42AA,16'h0055,1'b0,1'b0,2'd1,2'd2,4'd10}, // R10 bank 1 key 2
      '{1'b1,1'b0,16'h4555,16'h0020,1'b0,1'b0,2'd1,2'd1,4'd10}, // R10 bank 1 bypass
      '{1'b1,1'b0,16'h4000,16'h00A0,1'b0,1'b0,2'd1,2'd3,4'd3},  // R3 bank 1 setup
      '{1'b1,1'b1,16'h4ABC,16'h5555,1'b0,1'b0,2'd1,2'd3,4'd9},  // R9 busy write ignored
      '{1'b1,1'b0,16'h4ABC,16'h5555,1'b1,1'b0,2'd1,2'd1,4'd3},  // R3 bank 1 program
      '{1'b1,1'b0,16'h0000,16'h0090,1'b0,1'b0,2'd3,2'd1,4'd6},  // R6 exit cycle 1
      '{1'b1,1'b0,16'h0333,16'h0001,1'b0,1'b1,2'd1,2'd1,4'd8},  // R8 broken exit
      '{1'b1,1'b0,16'h0000,16'h0090,1'b0,1'b0,2'd3,2'd1,4'd6},  // R6 exit cycle 1
      '{1'b1,1'b0,16'h0FFF,16'h0000,1'b0,1'b0,2'd0,2'd1,4'd6},  // R6 exit cycle 2
      '{1'b1,1'b0,16'h4555,16'h00AA,1'b0,1'b0,2'd0,2'd3,4'd7},  // R7 reset key 1
      '{1'b1,1'b0,16'h42AA,16'h0055,1'b0,1'b0,2'd0,2'd3,4'd7},  // R7 reset key 2
      '{1'b1,1'b0,16'h4000,16'h00F0,1'b0,1'b0,2'd0,2'd0,4'd7},  // R7 reset done
      '{1'b1,1'b0,16'h0555,16'h00AA,1'b0,1'b0,2'd2,2'd0,4'd8},  // R8 start entry
      '{1'b1,1'b0,16'h0555,16'h0055,1'b0,1'b1,2'd0,2'd0,4'd8},  // R8 wrong address
      '{1'b1,1'b0,16'h0100,16'h1234,1'b0,1'b0,2'd0,2'd0,4'd11}, // R11 stray write
      '{1'b1,1'b0,16'h0555,16'h00AA,1'b0,1'b0,2'd2,2'd0,4'd4},  // R4 key 1
      '{1'b1,1'b0,16'h02AA,16'h0055,1'b0,1'b0,2'd2,2'd0,4'd4},  // R4 key 2
      '{1'b1,1'b0,16'h0555,16'h00A0,1'b0,1'b0,2'd2,2'd0,4'd4},  // R4 program cmd
      '{1'b1,1'b0,16'h0200,16'hBEEF,1'b1,1'b0,2'd0,2'd0,4'd4},  // R4 program data
      '{1'b1,1'b0,16'h1555,16'h00AA,1'b0,1'b0,2'd2,2'd0,4'd2},  // R2 upper bits ignored
      '{1'b1,1'b0,16'h32AA,16'h0055,1'b0,1'b0,2'd2,2'd0,4'd2},  // R2
      '{1'b1,1'b0,16'h2555,16'h0020,1'b0,1'b0,2'd1,2'd0,4'd2},  // R2
      '{1'b0,1'b0,16'h0555,16'h00A0,1'b0,1'b0,2'd1,2'd0,4'd9},  // R9 no strobe
      '{1'b1,1'b0,16'h0000,16'h0090,1'b0,1'b0,2'd3,2'd0,4'd6},  // R6
      '{1'b1,1'b0,16'h0000,16'h0000,1'b0,1'b0,2'd0,2'd0,4'd6}   // R6
   };

   task automatic drive(input logic en, input logic bsy, input logic [15:0] a, input logic [15:0] d);
      wr_en = en; busy = bsy; wr_addr = a; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; busy = 1'b0;
   endtask

   task automatic check(input bit ok, input int rq, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL R%0d actual=%h expected=%h", rq, act, exp);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] em;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      check(bank_mode == 8'h00 && !prog_req && !cmd_err, 1,
            {55'd0, bank_mode, prog_req}, 64'd0);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i].en, VEC[i].bsy, VEC[i].a, VEC[i].d);
         em = {4'h0, VEC[i].m1, VEC[i].m0};
         check(bank_mode == em && prog_req == VEC[i].xp && cmd_err == VEC[i].xi,
               int'(VEC[i].rq), {54'd0, bank_mode, prog_req, cmd_err},
               {54'd0, em, VEC[i].xp, VEC[i].xi});
         if (VEC[i].xp)
            check(prog_addr == VEC[i].a && prog_data == VEC[i].d, int'(VEC[i].rq),
                  {32'd0, prog_addr, prog_data}, {32'd0, VEC[i].a, VEC[i].d});
      end

      // R8 broken reset sequence inside bypass returns to bypass idle
      drive(1'b1, 1'b0, 16'h0555, 16'h00AA);
      drive(1'b1, 1'b0, 16'h02AA, 16'h0055);
      drive(1'b1, 1'b0, 16'h0555, 16'h0020);
      drive(1'b1, 1'b0, 16'h0555, 16'h00AA);
      check(bank_mode == 8'h03, 7, {56'd0, bank_mode}, 64'h03);
      drive(1'b1, 1'b0, 16'h0555, 16'h0055);
      check(bank_mode == 8'h01 && cmd_err, 8, {55'd0, bank_mode, cmd_err}, {55'd0, 8'h01, 1'b1});

      // R1 reset while a bank sits in bypass with a program pending
      drive(1'b1, 1'b0, 16'h0000, 16'h00A0);
      rst = 1'b1;
      @(posedge clk); @(negedge clk);
      @(posedge clk); @(negedge clk);
      rst = 1'b0;
      check(bank_mode == 8'h00 && !prog_req && !cmd_err, 1,
            {55'd0, bank_mode, prog_req}, 64'd0);
      // R1 next write after reset is not taken as program data
      drive(1'b1, 1'b0, 16'h0042, 16'h7777);
      check(!prog_req && bank_mode == 8'h00, 1, {55'd0, bank_mode, prog_req}, 64'd0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule